// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block collects eight interrupt request lines, ranks them by a rotating priority, and raises a single interrupt output toward a processor when the best unmasked request outranks whatever is already being serviced. Software programs it through a byte-wide port with a one-bit address. Writes to address 0 carry the first initialization word or one of two operation command words, chosen by bits 4 and 3. Writes to address 1 carry the remaining initialization words and, in normal operation, the mask. Reads return the request, in-service or mask register, or a poll result.

An acknowledge strobe from the processor marks the winning input as in service and presents an interrupt vector: a programmable base plus the input number. End-of-interrupt commands clear in-service bits, and some of them also rotate the priority. Each input can be edge or level sensitive, chosen by a separate trigger-mode register whose writable bits are fixed per instance by a parameter. A cascade flag input tells the controller that input 2 feeds from a downstream controller, which matters in fully-nested mode.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the interrupt output is low, the mask, request and in-service registers read 0, the trigger-mode register is 0, and the sequencer is in normal mode.
- R2: An address-0 write with bit 4 set starts initialization: bit 0 says whether a mode word follows, and the mask, priority base, special mask and read selection are cleared. The next address-1 write sets the vector base to the value AND 0xF8, the one after is discarded, and if a mode word was announced a third write sets fully-nested mode from bit 4 and auto-EOI from bit 1. Both modes are cleared at start when no mode word is announced.
- R3: In normal mode an address-1 write loads the mask register, and an address-1 read returns it.
- R4: For an edge-mode input, a request is latched only when the line goes from low to high compared with the level seen on the previous clock; a line held high does not request again.
- R5: For a level-mode input, the request bit follows the line every clock and is not cleared by an acknowledge.
- R6: Priority runs from the base input upward modulo 8. The interrupt output is high exactly when the best unmasked request ranks strictly above the best in-service bit.
- R7: On acknowledge the vector output equals the vector base plus the winning input, or base plus 7 when nothing qualifies; the winner's in-service bit is set and, for edge mode only, its request bit cleared.
- R8: In auto-EOI mode an acknowledge leaves the in-service register unchanged, and when rotate-on-auto-EOI is on the base becomes the winner plus 1.
- R9: An address-0 write with bits 4 and 3 clear is decoded by bits 7:5: 0 clears and 4 sets rotate-on-auto-EOI; 1 clears the best in-service bit; 5 does so and sets the base to that input plus 1; 3 clears the in-service bit named by bits 2:0; 7 does so and sets the base to that input plus 1; 6 sets the base to bits 2:0 plus 1 modulo 8; 2 does nothing.
- R10: An address-0 write with bit 4 clear and bit 3 set arms poll when bit 2 is 1, selects the address-0 read source from bit 0 when bit 1 is 1 (1 = in-service, 0 = request), and loads special mask mode from bit 5 when bit 6 is 1.
- R11: A read while poll is armed returns the winning input number in bits 2:0 (upper bits 0), clears that input's request and in-service bits, returns 7 when no input qualifies, and disarms poll.
- R12: A trigger-mode write stores the data AND the instance parameter `TRIG_MASK` (bit set = level mode); initialization word 1 discards pending edge-mode requests and keeps level-mode ones.
- R13: In fully-nested mode with the cascade flag high, in-service bit 2 is not counted when ranking the current service level.
- R14: In special mask mode, in-service bits of masked inputs do not block lower-ranked requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register port address |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe (commits poll side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid combinationally while addressed |
| trig_wr | input | 1 | Write strobe for the trigger-mode register |
| trig_mode | output | 8 | Current trigger-mode register |
| irq_in | input | 8 | Interrupt request lines |
| cascade_in | input | 1 | Input 2 is fed by a downstream controller |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Interrupt acknowledge strobe |
| vec_out | output | 8 | Vector for the current acknowledge |

## Verification
The bench drives priority rotation through every command that moves the base, so a resolver that searched from input 0, or an EOI that rotated to the wrong input, hands back the wrong vector on the next acknowledge. It holds edge lines high across an acknowledge to catch a design that re-latches a level as a fresh edge, and acknowledges level inputs to catch one that clears their request. Poll with nothing pending, acknowledge with nothing pending, the discarded third initialization word and the flush of edge requests by initialization are each probed, as are the cascade and special-mask exclusions, whose absence keeps the interrupt output low when it should rise. Random rounds mix masks, bases and request patterns against a bench ranking function.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NIN = 8;
  localparam int IW  = 3;
  localparam int CASC_SLOT = 2;

  typedef logic [NIN-1:0] vec_t;
  typedef logic [IW-1:0]  idx_t;
  typedef logic [IW:0]    rank_t;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_SKIP = 2'd2,
    SEQ_MODE = 2'd3
  } seq_e;

  // Rank of the best set bit counted from base; NIN when no bit is set.
  function automatic rank_t rel_rank(vec_t m, idx_t base);
    rank_t r;
    idx_t  j;
    r = rank_t'(NIN);
    for (int k = NIN - 1; k >= 0; k--) begin
      j = base + idx_t'(k);
      if (m[j]) r = rank_t'(k);
    end
    return r;
  endfunction

  function automatic idx_t abs_idx(rank_t r, idx_t base);
    return r[IW-1:0] + base;
  endfunction
endpackage

// File: rtl/irq_trig_reg.sv
module irq_trig_reg
  import irq_ctrl_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK = 8'hF8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  vec_t din,
  output vec_t trig_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  trig_q <= '0;
    else if (wr) trig_q <= din & vec_t'(TRIG_MASK);
  end
endmodule

// File: rtl/irq_req_unit.sv
module irq_req_unit
  import irq_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  vec_t lines,
  input  vec_t trig,
  input  vec_t clr,
  input  logic flush,
  output vec_t irr_q,
  output vec_t lvl_q
);
  vec_t cap;
  vec_t rise;

  always_comb begin
    rise = lines & ~lvl_q;
    cap  = (trig & lines) | (~trig & (irr_q | rise));
    cap  = cap & ~clr;
    if (flush) cap = cap & trig;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      lvl_q <= '0;
    end else begin
      irr_q <= cap;
      lvl_q <= flush ? '0 : lines;
    end
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_ctrl_pkg::*;
(
  input  vec_t irr,
  input  vec_t imr,
  input  vec_t isr,
  input  idx_t base,
  input  logic nested,
  input  logic smm,
  input  logic cascade,
  output logic win_vld,
  output idx_t win
);
  vec_t  svc;
  rank_t req_rank;
  rank_t svc_rank;

  always_comb begin
    svc = isr;
    if (nested && cascade) svc[CASC_SLOT] = 1'b0;
    if (smm) svc = svc & ~imr;
    req_rank = rel_rank(irr & ~imr, base);
    svc_rank = rel_rank(svc, base);
    win_vld  = req_rank < svc_rank;
    win      = abs_idx(req_rank, base);
  end
endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
  import irq_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic addr,
  input  logic wr_en,
  input  logic rd_en,
  input  logic inta,
  input  logic [7:0] wdata,
  input  vec_t trig,
  input  logic win_vld,
  input  idx_t win,
  output vec_t imr_q,
  output vec_t isr_q,
  output idx_t base_q,
  output logic [7:0] vbase_q,
  output logic nested_q,
  output logic aeoi_q,
  output logic smm_q,
  output logic rsel_q,
  output logic poll_q,
  output vec_t req_clr,
  output logic flush
);
  seq_e  seq_q;
  logic  ic4_q;
  logic  raeoi_q;
  logic  icw1, ocw3, ocw2, dat1;
  logic  ack_hit, poll_hit;
  rank_t eoi_rank;
  idx_t  eoi_idx;
  logic  eoi_any;
  idx_t  arg;

  always_comb begin
    icw1     = wr_en && !addr && wdata[4];
    ocw3     = wr_en && !addr && !wdata[4] && wdata[3];
    ocw2     = wr_en && !addr && !wdata[4] && !wdata[3];
    dat1     = wr_en && addr;
    ack_hit  = inta && win_vld;
    poll_hit = rd_en && poll_q && win_vld;
    eoi_rank = rel_rank(isr_q, base_q);
    eoi_idx  = abs_idx(eoi_rank, base_q);
    eoi_any  = !eoi_rank[IW];
    arg      = wdata[IW-1:0];
    flush    = icw1;
    req_clr  = '0;
    if (ack_hit && !trig[win]) req_clr[win] = 1'b1;
    if (poll_hit)              req_clr[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q    <= SEQ_RUN;
      ic4_q    <= 1'b0;
      raeoi_q  <= 1'b0;
      imr_q    <= '0;
      isr_q    <= '0;
      base_q   <= '0;
      vbase_q  <= '0;
      nested_q <= 1'b0;
      aeoi_q   <= 1'b0;
      smm_q    <= 1'b0;
      rsel_q   <= 1'b0;
      poll_q   <= 1'b0;
    end else if (icw1) begin
      ic4_q  <= wdata[0];
      imr_q  <= '0;
      base_q <= '0;
      smm_q  <= 1'b0;
      rsel_q <= 1'b0;
      seq_q  <= SEQ_BASE;
      if (!wdata[0]) begin
        nested_q <= 1'b0;
        aeoi_q   <= 1'b0;
      end
    end else if (ocw3) begin
      if (wdata[2]) poll_q <= 1'b1;
      if (wdata[1]) rsel_q <= wdata[0];
      if (wdata[6]) smm_q  <= wdata[5];
    end else if (ocw2) begin
      case (wdata[7:5])
        3'd0: raeoi_q <= 1'b0;
        3'd4: raeoi_q <= 1'b1;
        3'd1: if (eoi_any) isr_q[eoi_idx] <= 1'b0;
        3'd5: if (eoi_any) begin
          isr_q[eoi_idx] <= 1'b0;
          base_q         <= eoi_idx + idx_t'(1);
        end
        3'd3: isr_q[arg] <= 1'b0;
        3'd6: base_q <= arg + idx_t'(1);
        3'd7: begin
          isr_q[arg] <= 1'b0;
          base_q     <= arg + idx_t'(1);
        end
        default: ;
      endcase
    end else if (dat1) begin
      case (seq_q)
        SEQ_RUN:  imr_q <= wdata;
        SEQ_BASE: begin
          vbase_q <= wdata & 8'hF8;
          seq_q   <= SEQ_SKIP;
        end
        SEQ_SKIP: seq_q <= ic4_q ? SEQ_MODE : SEQ_RUN;
        default: begin
          nested_q <= wdata[4];
          aeoi_q   <= wdata[1];
          seq_q    <= SEQ_RUN;
        end
      endcase
    end else if (ack_hit) begin
      if (!aeoi_q)      isr_q[win] <= 1'b1;
      else if (raeoi_q) base_q     <= win + idx_t'(1);
    end else if (rd_en && poll_q) begin
      poll_q <= 1'b0;
      if (win_vld) isr_q[win] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
  import irq_ctrl_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       trig_wr,
  output logic [7:0] trig_mode,
  input  logic [7:0] irq_in,
  input  logic       cascade_in,
  output logic       int_out,
  input  logic       inta,
  output logic [7:0] vec_out
);
  vec_t       trig_q, irr_q, lvl_q, imr_q, isr_q, req_clr;
  idx_t       base_q, win_idx;
  logic [7:0] vbase_q;
  logic       nested_q, aeoi_q, smm_q, rsel_q, poll_q, flush, win_vld;
  logic [7:0] pick_byte;

  irq_trig_reg #(.TRIG_MASK(TRIG_MASK)) u_trig (
    .clk(clk), .rst_n(rst_n), .wr(trig_wr), .din(wdata), .trig_q(trig_q)
  );

  irq_req_unit u_req (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .trig(trig_q),
    .clr(req_clr), .flush(flush), .irr_q(irr_q), .lvl_q(lvl_q)
  );

  irq_resolver u_res (
    .irr(irr_q), .imr(imr_q), .isr(isr_q), .base(base_q),
    .nested(nested_q), .smm(smm_q), .cascade(cascade_in),
    .win_vld(win_vld), .win(win_idx)
  );

  irq_ctl_unit u_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .inta(inta), .wdata(wdata), .trig(trig_q), .win_vld(win_vld), .win(win_idx),
    .imr_q(imr_q), .isr_q(isr_q), .base_q(base_q), .vbase_q(vbase_q),
    .nested_q(nested_q), .aeoi_q(aeoi_q), .smm_q(smm_q), .rsel_q(rsel_q),
    .poll_q(poll_q), .req_clr(req_clr), .flush(flush)
  );

  always_comb begin
    pick_byte = {5'd0, (win_vld ? win_idx : idx_t'(7))};
    if (poll_q)      rdata = pick_byte;
    else if (addr)   rdata = imr_q;
    else if (rsel_q) rdata = isr_q;
    else             rdata = irr_q;
    vec_out   = vbase_q + pick_byte;
    int_out   = win_vld;
    trig_mode = trig_q;
  end
endmodule

// File: rtl/irq_ctrl8_chk.sv
module irq_ctrl8_chk
  import irq_ctrl_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic addr,
  input logic wr_en,
  input logic rd_en,
  input logic inta,
  input logic [7:0] wdata,
  input logic int_out,
  input vec_t irr_q,
  input vec_t imr_q,
  input vec_t isr_q,
  input logic poll_q,
  input logic aeoi_q,
  input logic win_vld,
  input idx_t win_idx
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (imr_q == '0 && isr_q == '0 && irr_q == '0 && !poll_q));

  assert_init_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (imr_q == '0));

  assert_int_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_q & ~imr_q) != '0));

  assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && win_vld && !aeoi_q && !wr_en && !rd_en) |=> isr_q[$past(win_idx)]);

  assert_aeoi_keeps_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && win_vld && aeoi_q && !wr_en && !rd_en) |=> (isr_q == $past(isr_q)));

  assert_poll_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_q && !wr_en) |=> !poll_q);
endmodule

bind irq_ctrl8 irq_ctrl8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .inta(inta), .wdata(wdata), .int_out(int_out), .irr_q(irr_q),
  .imr_q(imr_q), .isr_q(isr_q), .poll_q(poll_q), .aeoi_q(aeoi_q),
  .win_vld(win_vld), .win_idx(win_idx)
);

// File: tb/irq_ctrl8_tb.sv
module irq_ctrl8_tb;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, trig_wr = 1'b0;
  logic       inta = 1'b0, cascade_in = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, trig_mode, vec_out;
  logic       int_out;
  int         n_chk = 0, n_err = 0;
  bit         done = 0;

  irq_ctrl8 u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .trig_wr(trig_wr), .trig_mode(trig_mode),
    .irq_in(irq_in), .cascade_in(cascade_in), .int_out(int_out),
    .inta(inta), .vec_out(vec_out)
  );

  always #(CLK_NS / 2) clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Input that wins from base among set bits, 8 when none.
  function automatic int rank_pick(logic [7:0] m, int base);
    for (int k = 0; k < 8; k++)
      if (m[(base + k) % 8]) return (base + k) % 8;
    return 8;
  endfunction

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic twr(logic [7:0] d);
    @(negedge clk); wdata = d; trig_wr = 1'b1;
    @(negedge clk); trig_wr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); inta = 1'b1; #1 v = vec_out;
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic pulse(logic [7:0] p);
    @(negedge clk); irq_in = irq_in | p;
    @(negedge clk); irq_in = irq_in & ~p;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] m, pat, vis;
    int rb, base, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    check("R1 int_out", {7'd0, int_out}, 8'h00);
    check("R1 trig", trig_mode, 8'h00);
    rd(1'b1, v); check("R1 mask", v, 8'h00);
    rd(1'b0, v); check("R1 req", v, 8'h00);
    // R12 trigger mask
    twr(8'hFF); check("R12 trig masked", trig_mode, 8'hF8);
    twr(8'h00);
    // R2 init with mode word
    wr(1'b0, 8'h11); wr(1'b1, 8'h4B); wr(1'b1, 8'hAA); wr(1'b1, 8'h00);
    rd(1'b1, v); check("R2 skip word ignored", v, 8'h00);
    // R4/R6/R7 edge request and ack
    pulse(8'h08);
    check("R6 int raised", {7'd0, int_out}, 8'h01);
    ack(v); check("R7 vector base+3", v, 8'h4B);
    check("R6 int dropped after ack", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R10 isr select", v, 8'h08);
    wr(1'b0, 8'h0A); rd(1'b0, v); check("R7 edge req cleared", v, 8'h00);
    // R4 held line, nested blocking
    @(negedge clk); irq_in[5] = 1'b1; settle();
    check("R6 blocked by in-service", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h20);
    check("R9 eoi unblocks", {7'd0, int_out}, 8'h01);
    ack(v); check("R7 vector 5", v, 8'h4D);
    repeat (3) settle();
    rd(1'b0, v); check("R4 held high no re-request", v, 8'h00);
    wr(1'b0, 8'h20); irq_in[5] = 1'b0; settle();
    // R9 EOI codes
    pulse(8'h42);
    ack(v); check("R7 vector 1", v, 8'h49);
    check("R6 lower ranked waits", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h61);
    check("R9 specific eoi", {7'd0, int_out}, 8'h01);
    ack(v); check("R9 vector 6", v, 8'h4E);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R9 isr after spec eoi", v, 8'h40);
    wr(1'b0, 8'hE6);
    rd(1'b0, v); check("R9 rotate spec eoi clears", v, 8'h00);
    pulse(8'h81);
    ack(v); check("R9 base 7 picks 7", v, 8'h4F);
    wr(1'b0, 8'hA0);
    check("R9 rotate eoi int", {7'd0, int_out}, 8'h01);
    ack(v); check("R9 base 0 picks 0", v, 8'h48);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'hC3);
    pulse(8'h24);
    ack(v); check("R9 set priority base 4", v, 8'h4D);
    wr(1'b0, 8'h20);
    ack(v); check("R9 next 2", v, 8'h4A);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h40);
    check("R9 nop no int", {7'd0, int_out}, 8'h00);
    ack(v); check("R7 none gives base+7", v, 8'h4F);
    pulse(8'h09);
    ack(v); check("R9 nop kept base 4", v, 8'h48);
    wr(1'b0, 8'h20);
    ack(v); check("R9 then 3", v, 8'h4B);
    wr(1'b0, 8'h20);
    // R3 mask
    wr(1'b1, 8'h10); rd(1'b1, v); check("R3 mask readback", v, 8'h10);
    pulse(8'h10);
    check("R3 masked no int", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, v); check("R3 masked still requested", v, 8'h10);
    wr(1'b1, 8'h00);
    check("R3 unmask int", {7'd0, int_out}, 8'h01);
    ack(v); check("R3 vector 4", v, 8'h4C);
    wr(1'b0, 8'h20);
    // R11 poll
    pulse(8'h40);
    wr(1'b0, 8'h0C); rd(1'b0, v); check("R11 poll value", v, 8'h06);
    rd(1'b0, v); check("R11 disarmed and cleared", v, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R11 isr clear", v, 8'h00);
    wr(1'b0, 8'h0A);
    wr(1'b0, 8'h0C); rd(1'b1, v); check("R11 poll none", v, 8'h07);
    // R5 level
    twr(8'h08);
    @(negedge clk); irq_in[3] = 1'b1; settle();
    rd(1'b0, v); check("R5 level follows", v, 8'h08);
    ack(v); check("R5 vector 3", v, 8'h4B);
    rd(1'b0, v); check("R5 ack keeps level req", v, 8'h08);
    wr(1'b0, 8'h20);
    check("R5 int again", {7'd0, int_out}, 8'h01);
    @(negedge clk); irq_in[3] = 1'b0; settle();
    rd(1'b0, v); check("R5 level drop", v, 8'h00);
    // R12 flush on init
    @(negedge clk); irq_in[3] = 1'b1; settle();
    pulse(8'h20);
    rd(1'b0, v); check("R12 pre-flush", v, 8'h28);
    wr(1'b0, 8'h10); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
    rd(1'b0, v); check("R12 edge dropped level kept", v, 8'h08);
    rd(1'b1, v); check("R2 mask cleared", v, 8'h00);
    @(negedge clk); irq_in[3] = 1'b0; settle();
    twr(8'h00);
    // R8 auto-EOI with rotation
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
    wr(1'b0, 8'h80);
    pulse(8'h04);
    ack(v); check("R8 vector 2", v, 8'h42);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R8 isr untouched", v, 8'h00);
    pulse(8'h0C);
    ack(v); check("R8 rotated base picks 3", v, 8'h43);
    ack(v); check("R8 then 2", v, 8'h42);
    wr(1'b0, 8'h00);
    // R13 nested with cascade
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h10);
    pulse(8'h04);
    ack(v); check("R13 vector 2", v, 8'h42);
    pulse(8'h04);
    check("R13 no cascade blocks", {7'd0, int_out}, 8'h00);
    cascade_in = 1'b1; #1;
    check("R13 cascade passes", {7'd0, int_out}, 8'h01);
    cascade_in = 1'b0;
    // R14 special mask
    wr(1'b0, 8'h10); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
    wr(1'b0, 8'h20);
    pulse(8'h02);
    ack(v); check("R14 vector 1", v, 8'h41);
    pulse(8'h10);
    wr(1'b1, 8'h02);
    check("R14 mask alone blocks", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h68);
    check("R14 special mask passes", {7'd0, int_out}, 8'h01);
    wr(1'b0, 8'h48);
    check("R14 special mask off", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h20);
    // R6/R7 random rounds
    void'($urandom(32'd1234));
    for (int t = 0; t < 40; t++) begin
      m   = 8'($urandom());
      pat = 8'($urandom());
      rb  = int'($urandom() % 8);
      wr(1'b0, 8'h10); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
      wr(1'b1, m);
      wr(1'b0, 8'hC0 | 8'(rb));
      base = (rb + 1) % 8;
      pulse(pat);
      vis = pat & ~m;
      check("R6 random int", {7'd0, int_out}, {7'd0, (vis != 0)});
      w = rank_pick(vis, base);
      ack(v);
      check("R7 random vector", v, 8'h40 + 8'((w == 8) ? 7 : w));
      wr(1'b0, 8'h20);
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule